// File: doc/BRIEF.md
# Address-Masked GPIO Data Port

This block is the data and direction register pair of a 12-pin general-purpose I/O port. The bus address of a data access also carries a per-pin select mask. The bits from position 2 upward name the port bits that the access may touch. A single write can therefore drive any subset of pins high or low in one bus cycle, and it leaves the other pins alone. Software never needs to read the port, merge a new value and write it back.

The same mask filters reads, so a driver can sample one pin or a group of pins without shifting or masking in software. A separate direction register decides, for each pin, whether that pin drives its output or is an input. For an output pin the read value comes from the stored output value. For an input pin it comes from a two-stage synchronized copy of the pin.

Top module: `masked_gpio_port`

## Requirements
- R1: After a synchronous reset, the output register and the direction register are zero, so `pins_out` and `pins_oe` are zero and every pin is an input.
- R2: A write with `bus_addr[15]`=0 stores `bus_wdata[i]` into output bit i only where `bus_addr[2+i]`=1. Every other output bit keeps its value. The new value appears on `pins_out` after the clock edge that takes the write.
- R3: A read with `bus_addr[15]`=0 returns port bit i on `bus_rdata[i]` where `bus_addr[2+i]`=1. Each unselected bit and `bus_rdata[31:12]` read as zero. The read path is combinational from the address.
- R4: Offset 0x3FFC selects all 12 bits, so a write at that offset loads the whole port and a read at that offset returns the whole port.
- R5: Offset 0x0004 selects port bit 0 alone, both for writes and for reads.
- R6: Offset 0x0000 selects no bit. A write there leaves the port unchanged, and a read there returns zero.
- R7: `bus_addr[1:0]` and `bus_addr[14]` have no effect on any access.
- R8: Any address with `bus_addr[15]`=1 reaches the direction register. A write there stores all 12 bits of `bus_wdata` with no mask, and a read there returns the direction register. `pins_oe[i]` equals direction bit i, where 1 means output.
- R9: For a pin whose direction bit is 1, the port read value is the output register bit. For a pin whose direction bit is 0, the port read value is the pin input after two clock edges of synchronization. A change on `pins_in` is not yet visible after one edge.
- R10: `pins_out` always shows the output register, whatever the direction. A write still updates the output bits of input pins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 16 | Word byte address. Bits 13:2 form the pin mask, and bit 15 selects the direction register |
| bus_wdata | input | 32 | Write data. Bits 11:0 are used |
| bus_we | input | 1 | Write strobe. The write takes effect at the rising clock edge |
| bus_rdata | output | 32 | Read data for `bus_addr`. It is combinational |
| pins_in | input | 12 | Asynchronous pin input levels |
| pins_out | output | 12 | Output register value for the pin drivers |
| pins_oe | output | 12 | Per-pin output enable |

## Verification
Two things can fall in the same cycle: a masked data write and a change on asynchronous pins. The bench provokes this by changing `pins_in` on input-direction pins in the same cycle as a full-mask write. It then judges two results. First, `pins_out` must take the written value for every bit, including the bits of input pins. Second, a full-port read must combine the new output bits with the old synchronized inputs until two edges have passed, and then with the new inputs.

// File: rtl/gpio_mask_pkg.sv
package gpio_mask_pkg;

    localparam int PORT_W      = 12;
    localparam int BUS_AW      = 16;
    localparam int BUS_DW      = 32;
    localparam int MASK_LSB    = 2;
    localparam int DIR_SEL_BIT = 15;

    typedef struct packed {
        logic              sel_dir;
        logic              sel_data;
        logic [PORT_W-1:0] mask;
    } access_t;

    function automatic logic [PORT_W-1:0] merge_masked(
        input logic [PORT_W-1:0] old_val,
        input logic [PORT_W-1:0] new_val,
        input logic [PORT_W-1:0] mask
    );
        return (old_val & ~mask) | (new_val & mask);
    endfunction

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
    import gpio_mask_pkg::*;
(
    input  logic [BUS_AW-1:0] addr,
    output access_t           acc
);
    always_comb begin
        acc.sel_dir  = addr[DIR_SEL_BIT];
        acc.sel_data = ~addr[DIR_SEL_BIT];
        acc.mask     = addr[MASK_LSB +: PORT_W];
    end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int WIDTH  = 12,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst)
                stg[s] <= '0;
            else if (s == 0)
                stg[s] <= async_in;
            else
                stg[s] <= stg[(s == 0) ? 0 : s-1];
        end
    end

    assign sync_out = stg[STAGES-1];
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_mask_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  access_t           acc,
    input  logic [PORT_W-1:0] wdata,
    output logic [PORT_W-1:0] out_q,
    output logic [PORT_W-1:0] dir_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
            dir_q <= '0;
        end else if (we) begin
            if (acc.sel_data)
                out_q <= merge_masked(out_q, wdata, acc.mask);
            if (acc.sel_dir)
                dir_q <= wdata;
        end
    end
endmodule

// File: rtl/masked_gpio_port.sv
module masked_gpio_port
    import gpio_mask_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [BUS_DW-1:0] bus_wdata,
    input  logic              bus_we,
    output logic [BUS_DW-1:0] bus_rdata,
    input  logic [PORT_W-1:0] pins_in,
    output logic [PORT_W-1:0] pins_out,
    output logic [PORT_W-1:0] pins_oe
);
    access_t           acc;
    logic [PORT_W-1:0] out_q;
    logic [PORT_W-1:0] dir_q;
    logic [PORT_W-1:0] pin_sync;
    logic [PORT_W-1:0] port_view;

    gpio_addr_decode u_dec (
        .addr (bus_addr),
        .acc  (acc)
    );

    gpio_in_sync #(.WIDTH(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (pins_in),
        .sync_out (pin_sync)
    );

    gpio_port_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (bus_we),
        .acc   (acc),
        .wdata (bus_wdata[PORT_W-1:0]),
        .out_q (out_q),
        .dir_q (dir_q)
    );

    always_comb begin
        port_view = (dir_q & out_q) | (~dir_q & pin_sync);
        bus_rdata = '0;
        if (acc.sel_dir)
            bus_rdata[PORT_W-1:0] = dir_q;
        else
            bus_rdata[PORT_W-1:0] = port_view & acc.mask;
    end

    assign pins_out = out_q;
    assign pins_oe  = dir_q;
endmodule

// File: rtl/masked_gpio_port_chk.sv
module masked_gpio_port_chk
    import gpio_mask_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [BUS_AW-1:0] bus_addr,
    input logic [BUS_DW-1:0] bus_wdata,
    input logic              bus_we,
    input logic [BUS_DW-1:0] bus_rdata,
    input logic [PORT_W-1:0] pins_out,
    input logic [PORT_W-1:0] pins_oe
);
    p_keep_unmasked_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_we && !bus_addr[DIR_SEL_BIT]) |=>
        (((pins_out ^ $past(pins_out)) & ~$past(bus_addr[MASK_LSB +: PORT_W])) == '0));

    p_take_masked_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_we && !bus_addr[DIR_SEL_BIT]) |=>
        (((pins_out ^ $past(bus_wdata[PORT_W-1:0])) & $past(bus_addr[MASK_LSB +: PORT_W])) == '0));

    p_read_filtered_r3: assert property (@(posedge clk) disable iff (rst)
        !bus_addr[DIR_SEL_BIT] |->
        ((bus_rdata[PORT_W-1:0] & ~bus_addr[MASK_LSB +: PORT_W]) == '0) &&
        (bus_rdata[BUS_DW-1:PORT_W] == '0));

    p_zero_offset_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_addr[BUS_AW-1:MASK_LSB] == '0) |-> (bus_rdata == '0));

    p_dir_unmasked_r8: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr[DIR_SEL_BIT]) |=> (pins_oe == $past(bus_wdata[PORT_W-1:0])));

    p_dir_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !(bus_we && bus_addr[DIR_SEL_BIT]) |=> $stable(pins_oe));

    p_out_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !(bus_we && !bus_addr[DIR_SEL_BIT]) |=> $stable(pins_out));
endmodule

bind masked_gpio_port masked_gpio_port_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .bus_rdata (bus_rdata),
    .pins_out  (pins_out),
    .pins_oe   (pins_oe)
);

// File: tb/test_masked_gpio_port.sv
module test_masked_gpio_port;
    import gpio_mask_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [BUS_AW-1:0] bus_addr = '0;
    logic [BUS_DW-1:0] bus_wdata = '0;
    logic              bus_we = 1'b0;
    logic [BUS_DW-1:0] bus_rdata;
    logic [PORT_W-1:0] pins_in = '0;
    logic [PORT_W-1:0] pins_out;
    logic [PORT_W-1:0] pins_oe;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    masked_gpio_port i_masked_gpio_port (
        .clk, .rst, .bus_addr, .bus_wdata, .bus_we, .bus_rdata,
        .pins_in, .pins_out, .pins_oe
    );

    typedef struct packed {
        logic        we;
        logic [15:0] waddr;
        logic [11:0] wdata;
        logic [15:0] raddr;
        logic [11:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 16'h3FFC, 12'hFFF, 16'h3FFC, 12'hFFF, 8'd4},  // R4 full port
        '{1'b1, 16'h0004, 12'h000, 16'h3FFC, 12'hFFE, 8'd5},  // R5 bit 0 only
        '{1'b1, 16'h0000, 12'h000, 16'h3FFC, 12'hFFE, 8'd6},  // R6 empty mask
        '{1'b1, 16'h03C0, 12'h000, 16'h3FFC, 12'hF0E, 8'd2},  // R2 mask 0x0F0
        '{1'b1, 16'h2814, 12'hFFF, 16'h003C, 12'h00F, 8'd3},  // R3 mask 0xA05
        '{1'b1, 16'h7FFF, 12'h5A5, 16'h3FFE, 12'h5A5, 8'd7},  // R7 low/bit14 ignored
        '{1'b0, 16'h0000, 12'h000, 16'h03C0, 12'h0A0, 8'd3},  // R3 partial read
        '{1'b0, 16'h0000, 12'h000, 16'h0000, 12'h000, 8'd6},  // R6 zero read
        '{1'b1, 16'h0004, 12'h0FE, 16'h0004, 12'h000, 8'd5}   // R5 bit0 cleared
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [11:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = {20'h0, d};
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    initial begin
        #400000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 pins_out", {20'h0, pins_out}, 32'h0);
        check("R1 pins_oe", {20'h0, pins_oe}, 32'h0);
        rd(16'h8000, r); check("R1 dir read", r, 32'h0);
        rd(16'h3FFC, r); check("R1 port read", r, 32'h0);

        // R8 direction register, unmasked
        wr(16'h8000, 12'h0F0);
        check("R8 pins_oe", {20'h0, pins_oe}, 32'h0F0);
        rd(16'h8000, r); check("R8 dir read", r, 32'h0F0);
        wr(16'h8000, 12'hFFF);
        check("R8 pins_oe all", {20'h0, pins_oe}, 32'hFFF);

        // vector table, all pins outputs
        for (int i = 0; i < NV; i++) begin
            if (VECS[i].we) wr(VECS[i].waddr, VECS[i].wdata);
            else @(negedge clk);
            rd(VECS[i].raddr, r);
            check($sformatf("R%0d vector %0d", VECS[i].req, i), r, {20'h0, VECS[i].exp});
        end
        check("R10 pins_out", {20'h0, pins_out}, 32'h5A4);

        // R9 mixed direction with synchronizer latency
        wr(16'h8000, 12'h00F);
        @(negedge clk);
        pins_in = 12'hC30;
        @(negedge clk);
        rd(16'h3FFC, r); check("R9 one edge", r, 32'h004);
        @(negedge clk);
        rd(16'h3FFC, r); check("R9 two edges", r, 32'hC34);

        // R10 write and pin change in the same cycle
        @(negedge clk);
        bus_addr  = 16'h3FFC;
        bus_wdata = 32'h0FF;
        bus_we    = 1'b1;
        pins_in   = 12'h3C0;
        @(negedge clk);
        bus_we = 1'b0;
        check("R10 out of input pins", {20'h0, pins_out}, 32'h0FF);
        rd(16'h3FFC, r); check("R9 old inputs", r, 32'hC3F);
        @(negedge clk);
        rd(16'h3FFC, r); check("R9 new inputs", r, 32'h3CF);
        rd(16'h0030, r); check("R3 input pins masked", r, 32'h00C);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule